// File: doc/BRIEF.md
# Add/Subtract Instruction Format Decoder

This block takes one 32-bit instruction word and decodes the three add/subtract encodings: immediate operand, extended-register operand and shifted-register operand. It is purely combinational. From the word it produces:

- the register numbers and the operation controls;
- an immediate value that is already scaled;
- the shift kind, shift amount and extend option that a later stage applies to the second register;
- for each of the first source and the destination, the meaning of register 31 (stack pointer or zero register).

Encodings that fall inside one of the three formats but are not allocated raise an illegal flag. An illegal encoding never enables a register write or a flag update. A word that is outside all three formats raises a not-matched flag, and every other output is then zero.

A pipeline decode stage places the block beside the other format decoders. It ORs the not-matched outputs together to find which decoder owns the word. Executing the operation, reading the register file and applying the extend or shift are handled elsewhere.

Top module: `adsub_decoder`

## Requirements
- R1: For a recognised word, `rd_o` equals bits 4:0, `rn_o` equals bits 9:5, `wide_o` equals bit 31, `is_sub_o` equals bit 30 and `set_flags_o` equals bit 29.
- R2: `fmt_o` is 01 when bits 28:24 are 10001 (immediate). It is 10 when bits 28:24 are 01011, bit 21 is 1 and bits 23:22 are 00 (extended register). It is 11 when bits 28:24 are 01011 and bit 21 is 0 (shifted register).
- R3: Any other word drives `nomatch_o` to 1 and every other output to zero. This includes bits 28:24 = 01011 with bit 21 set and bits 23:22 nonzero.
- R4: In the immediate format, `imm_o` is the 12-bit field in bits 21:10, zero-extended, when bit 22 is 0. It is that field shifted left by 12 when bit 22 is 1. `imm_o` is zero in the other formats and for an illegal immediate word. The immediate format drives `rm_o`, `shift_kind_o`, `shift_amt_o` and `ext_opt_o` to zero.
- R5: An immediate word with bit 23 set (shift codes 10 and 11) is illegal.
- R6: In the extended-register format, `rm_o` equals bits 20:16, `ext_opt_o` equals bits 15:13, `shift_amt_o` equals bits 12:10 zero-extended, and `shift_kind_o` is 00. `imm_o` is zero.
- R7: An extended-register word with bits 12:10 greater than 4 is illegal.
- R8: In the shifted-register format, `rm_o` equals bits 20:16 and `shift_kind_o` equals bits 23:22, with 00 for logical left, 01 for logical right and 10 for arithmetic right. `shift_amt_o` equals bits 15:10, and `ext_opt_o` is 000.
- R9: A shifted-register word is illegal when bits 23:22 are 11, or when bit 31 is 0 and bit 15 is 1 (an amount above 31 in 32-bit mode).
- R10: In the immediate and extended-register formats, `rn_sp_o` is 1 and `rd_sp_o` is the inverse of bit 29. In the shifted-register format both are 0. A value of 1 means register 31 names the stack pointer; 0 means it names the zero register.
- R11: `illegal_o` forces `reg_we_o` and `flag_we_o` to 0. A legal recognised word drives `reg_we_o` to 1 and `flag_we_o` to bit 29.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word under decode |
| nomatch_o | output | 1 | Word is outside all three formats |
| fmt_o | output | 2 | Operand source: 00 none, 01 immediate, 10 extended register, 11 shifted register |
| rd_o | output | 5 | Destination register number |
| rn_o | output | 5 | First source register number |
| rm_o | output | 5 | Second source register number (register formats only) |
| is_sub_o | output | 1 | 1 selects subtract, 0 selects add |
| set_flags_o | output | 1 | Operation updates the condition flags |
| wide_o | output | 1 | 1 for 64-bit operation, 0 for 32-bit |
| imm_o | output | 24 | Scaled immediate operand |
| shift_kind_o | output | 2 | Shift applied to the second register |
| shift_amt_o | output | 6 | Shift amount applied to the second register |
| ext_opt_o | output | 3 | Extend option for the second register |
| rn_sp_o | output | 1 | Register 31 in rn names the stack pointer |
| rd_sp_o | output | 1 | Register 31 in rd names the stack pointer |
| illegal_o | output | 1 | Unallocated encoding inside a recognised format |
| reg_we_o | output | 1 | Destination write permitted |
| flag_we_o | output | 1 | Flag update permitted |

## Verification
No register sits between `insn_i` and any output, so every result is due in the same cycle as the word that produces it. No result waits for a later edge. The driver applies a word on the rising edge and queues the expected output vector. The monitor takes that entry off the queue at the following falling edge, half a period later, once the decode logic has settled. It compares the entry with all outputs before the driver changes the word at the next rising edge. As a result, every queued item is matched to exactly the word that was on the input.

// File: rtl/adsub_pkg.sv
package adsub_pkg;

    localparam int INSN_W    = 32;
    localparam int REG_W     = 5;
    localparam int GRP_W     = 5;
    localparam int IMM12_W   = 12;
    localparam int IMM_LSL   = 12;
    localparam int IMM_W     = IMM12_W + IMM_LSL;
    localparam int AMT_W     = 6;
    localparam int OPT_W     = 3;
    localparam int IMM3_W    = 3;
    localparam int KIND_W    = 2;
    localparam int EXT_AMT_MAX = 4;

    localparam logic [GRP_W-1:0] GRP_IMM = 5'b10001;
    localparam logic [GRP_W-1:0] GRP_REG = 5'b01011;

    typedef enum logic [1:0] {
        FMT_NONE = 2'b00,
        FMT_IMM  = 2'b01,
        FMT_EXT  = 2'b10,
        FMT_SHF  = 2'b11
    } fmt_e;

    typedef enum logic [KIND_W-1:0] {
        SK_LSL  = 2'b00,
        SK_LSR  = 2'b01,
        SK_ASR  = 2'b10,
        SK_RSVD = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic                 wide;
        logic                 sub;
        logic                 setf;
        logic [GRP_W-1:0]     grp;
        logic [KIND_W-1:0]    shf;
        logic                 b21;
        logic [REG_W-1:0]     rm;
        logic [AMT_W-1:0]     imm6;
        logic [OPT_W-1:0]     opt;
        logic [IMM3_W-1:0]    imm3;
        logic [IMM12_W-1:0]   imm12;
        logic [REG_W-1:0]     rn;
        logic [REG_W-1:0]     rd;
    } fields_t;

endpackage

// File: rtl/adsub_fields.sv
module adsub_fields
    import adsub_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output fields_t           f_o
);
    localparam int RD_LO  = 0;
    localparam int RN_LO  = RD_LO + REG_W;
    localparam int LOW_LO = RN_LO + REG_W;
    localparam int RM_LO  = LOW_LO + AMT_W;
    localparam int B21    = RM_LO + REG_W;
    localparam int SHF_LO = B21 + 1;
    localparam int GRP_LO = SHF_LO + KIND_W;
    localparam int SF_BIT = GRP_LO + GRP_W;

    always_comb begin
        f_o.rd    = word_i[RD_LO  +: REG_W];
        f_o.rn    = word_i[RN_LO  +: REG_W];
        f_o.imm3  = word_i[LOW_LO +: IMM3_W];
        f_o.opt   = word_i[LOW_LO + IMM3_W +: OPT_W];
        f_o.imm6  = word_i[LOW_LO +: AMT_W];
        f_o.imm12 = word_i[LOW_LO +: IMM12_W];
        f_o.rm    = word_i[RM_LO  +: REG_W];
        f_o.b21   = word_i[B21];
        f_o.shf   = word_i[SHF_LO +: KIND_W];
        f_o.grp   = word_i[GRP_LO +: GRP_W];
        f_o.setf  = word_i[SF_BIT];
        f_o.sub   = word_i[SF_BIT + 1];
        f_o.wide  = word_i[SF_BIT + 2];
    end
endmodule

// File: rtl/adsub_classify.sv
module adsub_classify
    import adsub_pkg::*;
(
    input  logic [GRP_W-1:0]  grp_i,
    input  logic [KIND_W-1:0] shf_i,
    input  logic              b21_i,
    input  logic              wide_i,
    input  logic [IMM3_W-1:0] imm3_i,
    input  logic              amt_top_i,
    output fmt_e              fmt_o,
    output logic              illegal_o
);
    logic is_imm, is_reg, is_ext, is_shf;

    always_comb begin
        is_imm = (grp_i == GRP_IMM);
        is_reg = (grp_i == GRP_REG);
        is_ext = is_reg && b21_i && (shf_i == 2'b00);
        is_shf = is_reg && !b21_i;
    end

    always_comb begin
        if (is_imm)      fmt_o = FMT_IMM;
        else if (is_shf) fmt_o = FMT_SHF;
        else if (is_ext) fmt_o = FMT_EXT;
        else             fmt_o = FMT_NONE;
    end

    always_comb begin
        unique case (fmt_o)
            FMT_IMM:  illegal_o = shf_i[1];
            FMT_EXT:  illegal_o = (imm3_i > IMM3_W'(EXT_AMT_MAX));
            FMT_SHF:  illegal_o = (shf_i == SK_RSVD) || (!wide_i && amt_top_i);
            FMT_NONE: illegal_o = 1'b0;
        endcase
    end

    always_comb begin
        p_fmt_onehot_r2: assert ($onehot0({is_imm, is_ext, is_shf}))
            else $error("format match not exclusive");
    end
endmodule

// File: rtl/adsub_operands.sv
module adsub_operands
    import adsub_pkg::*;
(
    input  fmt_e               fmt_i,
    input  logic               illegal_i,
    input  logic               wide_i,
    input  logic               sub_i,
    input  logic               setf_i,
    input  logic [KIND_W-1:0]  shf_i,
    input  logic [REG_W-1:0]   rm_i,
    input  logic [AMT_W-1:0]   imm6_i,
    input  logic [OPT_W-1:0]   opt_i,
    input  logic [IMM3_W-1:0]  imm3_i,
    input  logic [IMM12_W-1:0] imm12_i,
    input  logic [REG_W-1:0]   rn_i,
    input  logic [REG_W-1:0]   rd_i,
    output logic [REG_W-1:0]   rd_o,
    output logic [REG_W-1:0]   rn_o,
    output logic [REG_W-1:0]   rm_o,
    output logic               is_sub_o,
    output logic               set_flags_o,
    output logic               wide_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic [KIND_W-1:0]  shift_kind_o,
    output logic [AMT_W-1:0]   shift_amt_o,
    output logic [OPT_W-1:0]   ext_opt_o,
    output logic               rn_sp_o,
    output logic               rd_sp_o,
    output logic               reg_we_o,
    output logic               flag_we_o
);
    logic [IMM_W-1:0] imm_plain, imm_scaled;

    always_comb begin
        imm_plain  = IMM_W'(imm12_i);
        imm_scaled = imm_plain << IMM_LSL;
    end

    always_comb begin
        rd_o = '0; rn_o = '0; rm_o = '0;
        is_sub_o = 1'b0; set_flags_o = 1'b0; wide_o = 1'b0;
        imm_o = '0; shift_kind_o = '0; shift_amt_o = '0; ext_opt_o = '0;
        rn_sp_o = 1'b0; rd_sp_o = 1'b0;
        reg_we_o = 1'b0; flag_we_o = 1'b0;
        if (fmt_i != FMT_NONE) begin
            rd_o        = rd_i;
            rn_o        = rn_i;
            is_sub_o    = sub_i;
            set_flags_o = setf_i;
            wide_o      = wide_i;
            reg_we_o    = !illegal_i;
            flag_we_o   = !illegal_i && setf_i;
        end
        unique case (fmt_i)
            FMT_IMM: begin
                if (!illegal_i) imm_o = shf_i[0] ? imm_scaled : imm_plain;
                rn_sp_o = 1'b1;
                rd_sp_o = !setf_i;
            end
            FMT_EXT: begin
                rm_o        = rm_i;
                ext_opt_o   = opt_i;
                shift_amt_o = AMT_W'(imm3_i);
                rn_sp_o     = 1'b1;
                rd_sp_o     = !setf_i;
            end
            FMT_SHF: begin
                rm_o         = rm_i;
                shift_kind_o = shf_i;
                shift_amt_o  = imm6_i;
            end
            FMT_NONE: begin
            end
        endcase
    end
endmodule

// File: rtl/adsub_decoder.sv
module adsub_decoder
    import adsub_pkg::*;
(
    input  logic [INSN_W-1:0]  insn_i,
    output logic               nomatch_o,
    output logic [1:0]         fmt_o,
    output logic [REG_W-1:0]   rd_o,
    output logic [REG_W-1:0]   rn_o,
    output logic [REG_W-1:0]   rm_o,
    output logic               is_sub_o,
    output logic               set_flags_o,
    output logic               wide_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic [KIND_W-1:0]  shift_kind_o,
    output logic [AMT_W-1:0]   shift_amt_o,
    output logic [OPT_W-1:0]   ext_opt_o,
    output logic               rn_sp_o,
    output logic               rd_sp_o,
    output logic               illegal_o,
    output logic               reg_we_o,
    output logic               flag_we_o
);
    fields_t f;
    fmt_e    fmt;
    logic    ill;

    adsub_fields u_fields (
        .word_i (insn_i),
        .f_o    (f)
    );

    adsub_classify u_class (
        .grp_i     (f.grp),
        .shf_i     (f.shf),
        .b21_i     (f.b21),
        .wide_i    (f.wide),
        .imm3_i    (f.imm3),
        .amt_top_i (f.imm6[AMT_W-1]),
        .fmt_o     (fmt),
        .illegal_o (ill)
    );

    adsub_operands u_ops (
        .fmt_i        (fmt),
        .illegal_i    (ill),
        .wide_i       (f.wide),
        .sub_i        (f.sub),
        .setf_i       (f.setf),
        .shf_i        (f.shf),
        .rm_i         (f.rm),
        .imm6_i       (f.imm6),
        .opt_i        (f.opt),
        .imm3_i       (f.imm3),
        .imm12_i      (f.imm12),
        .rn_i         (f.rn),
        .rd_i         (f.rd),
        .rd_o         (rd_o),
        .rn_o         (rn_o),
        .rm_o         (rm_o),
        .is_sub_o     (is_sub_o),
        .set_flags_o  (set_flags_o),
        .wide_o       (wide_o),
        .imm_o        (imm_o),
        .shift_kind_o (shift_kind_o),
        .shift_amt_o  (shift_amt_o),
        .ext_opt_o    (ext_opt_o),
        .rn_sp_o      (rn_sp_o),
        .rd_sp_o      (rd_sp_o),
        .reg_we_o     (reg_we_o),
        .flag_we_o    (flag_we_o)
    );

    always_comb begin
        fmt_o     = fmt;
        nomatch_o = (fmt == FMT_NONE);
        illegal_o = ill;
    end

    always_comb begin
        p_illegal_no_write_r11: assert (!(illegal_o && (reg_we_o || flag_we_o)))
            else $error("illegal word still enables a write");
        p_flag_needs_write_r11: assert (!flag_we_o || (reg_we_o && set_flags_o))
            else $error("flag update without a legal flag-setting word");
        p_nomatch_quiet_r3: assert (!nomatch_o || (!illegal_o && !reg_we_o && !rn_sp_o && !rd_sp_o))
            else $error("unmatched word drives controls");
        p_shifted_zero_reg_r10: assert (!(fmt_o == 2'b11) || (!rn_sp_o && !rd_sp_o))
            else $error("shifted format picked stack pointer");
        p_ext_amount_r7: assert (!(fmt_o == 2'b10 && !illegal_o) || (shift_amt_o <= AMT_W'(EXT_AMT_MAX)))
            else $error("legal extended word with amount above 4");
        p_narrow_amount_r9: assert (!(fmt_o == 2'b11 && !illegal_o && !wide_o) || !shift_amt_o[AMT_W-1])
            else $error("legal 32-bit shifted word with amount above 31");
    end
endmodule

// File: tb/adsub_decoder_test.sv
module adsub_decoder_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int EXP_W = 61;
    localparam int WATCHDOG_CYC = 20000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] insn = '0;
    logic        nomatch_o, is_sub_o, set_flags_o, wide_o, rn_sp_o, rd_sp_o;
    logic        illegal_o, reg_we_o, flag_we_o;
    logic [1:0]  fmt_o, shift_kind_o;
    logic [4:0]  rd_o, rn_o, rm_o;
    logic [23:0] imm_o;
    logic [5:0]  shift_amt_o;
    logic [2:0]  ext_opt_o;

    adsub_decoder uut (
        .insn_i(insn), .nomatch_o(nomatch_o), .fmt_o(fmt_o), .rd_o(rd_o),
        .rn_o(rn_o), .rm_o(rm_o), .is_sub_o(is_sub_o), .set_flags_o(set_flags_o),
        .wide_o(wide_o), .imm_o(imm_o), .shift_kind_o(shift_kind_o),
        .shift_amt_o(shift_amt_o), .ext_opt_o(ext_opt_o), .rn_sp_o(rn_sp_o),
        .rd_sp_o(rd_sp_o), .illegal_o(illegal_o), .reg_we_o(reg_we_o),
        .flag_we_o(flag_we_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [EXP_W-1:0] exp_q[$];
    logic [31:0]      word_q[$];
    string            tag_q[$];

    function automatic logic [EXP_W-1:0] model(input logic [31:0] w);
        logic nm, sub, sf, wide, rn_sp, rd_sp, ill, we, fwe;
        logic [1:0] fmt, kind;
        logic [4:0] rd, rn, rm;
        logic [23:0] imm;
        logic [5:0] amt;
        logic [2:0] opt;
        nm = 0; sub = 0; sf = 0; wide = 0; rn_sp = 0; rd_sp = 0; ill = 0;
        fmt = 0; kind = 0; rd = 0; rn = 0; rm = 0; imm = 0; amt = 0; opt = 0;
        if (w[28:24] == 5'b10001) fmt = 2'b01;
        else if (w[28:24] == 5'b01011 && !w[21]) fmt = 2'b11;
        else if (w[28:24] == 5'b01011 && w[23:22] == 2'b00) fmt = 2'b10;
        else nm = 1;
        if (!nm) begin
            rd = w[4:0]; rn = w[9:5]; wide = w[31]; sub = w[30]; sf = w[29];
        end
        case (fmt)
            2'b01: begin
                ill = w[23];
                if (!ill) imm = w[22] ? {w[21:10], 12'h000} : {12'h000, w[21:10]};
                rn_sp = 1; rd_sp = !w[29];
            end
            2'b10: begin
                rm = w[20:16]; opt = w[15:13]; amt = {3'b000, w[12:10]};
                ill = (w[12:10] > 3'd4); rn_sp = 1; rd_sp = !w[29];
            end
            2'b11: begin
                rm = w[20:16]; kind = w[23:22]; amt = w[15:10];
                ill = (w[23:22] == 2'b11) || (!w[31] && w[15]);
            end
            default: ;
        endcase
        we  = !nm && !ill;
        fwe = we && w[29];
        return {nm, fmt, rd, rn, rm, sub, sf, wide, imm, kind, amt, opt, rn_sp, rd_sp, ill, we, fwe};
    endfunction

    function automatic logic [31:0] mk_imm(input logic sf, op, s, input logic [1:0] sh,
                                           input logic [11:0] i12, input logic [4:0] rn, rd);
        return {sf, op, s, 5'b10001, sh, i12, rn, rd};
    endfunction

    function automatic logic [31:0] mk_ext(input logic sf, op, s, input logic [4:0] rm,
                                           input logic [2:0] opt, i3, input logic [4:0] rn, rd);
        return {sf, op, s, 5'b01011, 2'b00, 1'b1, rm, opt, i3, rn, rd};
    endfunction

    function automatic logic [31:0] mk_shf(input logic sf, op, s, input logic [1:0] k,
                                           input logic [4:0] rm, input logic [5:0] i6,
                                           input logic [4:0] rn, rd);
        return {sf, op, s, 5'b01011, k, 1'b0, rm, i6, rn, rd};
    endfunction

    task automatic drive(input logic [31:0] w, input string tag);
        @(posedge clk);
        insn = w;
        exp_q.push_back(model(w));
        word_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [EXP_W-1:0] e, a;
            logic [31:0] w;
            string t;
            e = exp_q.pop_front();
            w = word_q.pop_front();
            t = tag_q.pop_front();
            a = {nomatch_o, fmt_o, rd_o, rn_o, rm_o, is_sub_o, set_flags_o, wide_o,
                 imm_o, shift_kind_o, shift_amt_o, ext_opt_o, rn_sp_o, rd_sp_o,
                 illegal_o, reg_we_o, flag_we_o};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s word=%h actual=%h expected=%h", t, w, a, e);
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset-state style check: all-zero word decodes as not matched
        drive(32'h0000_0000, "R3 zero word");
        // R1 R4 immediate add, unshifted
        drive(mk_imm(1, 0, 0, 2'b00, 12'hABC, 5'd3, 5'd7), "R1 R4 imm plain");
        // R4 R10 immediate subtract, shift by 12, flags set, rd 31 -> zero register
        drive(mk_imm(0, 1, 1, 2'b01, 12'hFFF, 5'd31, 5'd31), "R4 R10 imm scaled");
        // R5 reserved immediate shifts
        drive(mk_imm(1, 0, 1, 2'b10, 12'h123, 5'd1, 5'd2), "R5 imm shift 10");
        drive(mk_imm(0, 1, 0, 2'b11, 12'h001, 5'd1, 5'd2), "R5 imm shift 11");
        // R6 R7 extended register, amount 4 legal, 5 and 7 illegal
        drive(mk_ext(1, 0, 0, 5'd9, 3'b110, 3'd4, 5'd31, 5'd31), "R6 R7 ext amt 4");
        drive(mk_ext(1, 1, 1, 5'd9, 3'b011, 3'd5, 5'd4, 5'd5), "R7 ext amt 5");
        drive(mk_ext(0, 0, 1, 5'd17, 3'b001, 3'd7, 5'd6, 5'd8), "R7 ext amt 7");
        drive(mk_ext(0, 1, 1, 5'd30, 3'b111, 3'd0, 5'd31, 5'd31), "R10 R11 ext flags");
        // R8 R9 shifted register
        drive(mk_shf(1, 0, 0, 2'b01, 5'd12, 6'd63, 5'd31, 5'd31), "R8 R10 shf LSR 63 wide");
        drive(mk_shf(0, 1, 1, 2'b10, 5'd12, 6'd31, 5'd1, 5'd2), "R8 R9 shf ASR 31 narrow");
        drive(mk_shf(0, 0, 0, 2'b00, 5'd12, 6'd32, 5'd1, 5'd2), "R9 shf narrow 32");
        drive(mk_shf(1, 0, 1, 2'b11, 5'd12, 6'd0, 5'd1, 5'd2), "R9 shf kind 11");
        // R2 R3 format boundaries
        drive({3'b111, 5'b01011, 2'b01, 1'b1, 21'h1FFFFF}, "R3 ext-like nonzero opt");
        drive({3'b111, 5'b10000, 24'hFFFFFF}, "R2 R3 near-immediate group");
        drive(32'hFFFF_FFFF, "R3 all ones");
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive({r[31:29], 5'b10001, r[23:0]}, "R4 R5 random imm");
            r = $urandom;
            drive({r[31:29], 5'b01011, 2'b00, 1'b1, r[20:0]}, "R6 R7 random ext");
            r = $urandom;
            drive({r[31:29], 5'b01011, r[23:22], 1'b0, r[20:0]}, "R8 R9 random shf");
            r = $urandom;
            drive(r, "R2 R11 random word");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule